// File: doc/BRIEF.md
# March Memory Self-Test Engine

This block runs a ten-operations-per-word march test on a word-addressed, single-port synchronous RAM with a read latency of one clock. A single-cycle `start` pulse launches a run over `WORDS` words beginning at `BASE`. The run covers six data backgrounds in turn. For each background the engine fills the array, then makes four read-modify passes, two upward and two downward. Each pass reads a word, checks it and writes the complement, so the background and its inverse alternate. A final upward read-only pass closes the background.

The engine drives the RAM address, write enable and write data itself and compares every read against the value it expects. A mismatch never halts the run. The mismatch sets a sticky error flag and forces the final verdict to fail. The first failing address, the data read there and the data expected are latched for diagnosis. A progress pulse marks every `PROG_STEP` word operations, and a one-cycle `done` pulse ends the run with `pass` valid from then on.

Top module: `mbist_march`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `pass`, `err_flag`, `prog_tick` and `ram_we` are 0, `ram_addr` is 0 and the three capture outputs are 0.
- R2: Per background, the fill element spends one cycle per word with `ram_we`=1. Every later element spends two cycles per word: a read cycle with `ram_we`=0, then a compare cycle. The compare cycle writes (`ram_we`=1) in elements 1 to 4 and does not write in element 5. A whole run is therefore 66·WORDS cycles.
- R3: Elements 0, 1, 2 and 5 step upward from `BASE`. Elements 3 and 4 start at `BASE+WORDS-1` and step down by one word.
- R4: The backgrounds P are applied in this order: 0x00000000, 0x0000FFFF, 0x00FF00FF, 0x0F0F0F0F, 0x33333333, 0x55555555.
- R5: Element 0 writes P. Element 1 expects P and writes ~P. Element 2 expects ~P and writes P. Element 3 expects P and writes ~P. Element 4 expects ~P and writes P. Element 5 expects P.
- R6: A mismatch does not stop the run or its write. It sets `err_flag`, which stays set until the next accepted start, and the run ends with `pass`=0.
- R7: Only the first mismatch of a run loads `fail_addr`, `fail_rdata` and `fail_exp`. They hold until the next accepted start, which clears them to 0.
- R8: A `start` pulse while `busy` is 1 is ignored: the run keeps its timing and its result.
- R9: `done` is high for exactly one cycle, the cycle after the last word operation. `busy` is 1 in that cycle. `pass` equals NOT `err_flag` from the `done` cycle until the next accepted start, and is 0 before the first run.
- R10: `prog_tick` pulses for one cycle after every `PROG_STEP` completed word operations, counting fill writes and compare cycles. A run yields 36·WORDS/PROG_STEP pulses.
- R11: Reset during a run returns the engine to idle with `err_flag` and the capture outputs cleared.
- R12: A mismatch on the very last compare of a run is captured and drops `pass` in the same `done` cycle. In that cycle the final `prog_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, taken only when idle |
| ram_rdata | input | DW | RAM read data, one cycle after address |
| ram_addr | output | AW | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DW | RAM write data |
| busy | output | 1 | Run in progress (including the done cycle) |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict, valid from done until next start |
| err_flag | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of first mismatch |
| fail_rdata | output | DW | Data read at first mismatch |
| fail_exp | output | DW | Data expected at first mismatch |
| prog_tick | output | 1 | Progress pulse |

## Verification
The end of a run is the critical cycle. The final word's compare, the last progress pulse and the `done` pulse resolve together, so an error seen there must reach the first-failure capture and the verdict without a one-cycle lag. The bench provokes this by corrupting one bit of read data only during the final read-only element of the last background, at the top address. It then expects `pass`=0, the captured address `BASE+WORDS-1`, read data 0x55555554 against 0x55555555, and `prog_tick` high in the `done` cycle. Every other cycle of each run is compared against an address/enable/data trace that the bench rebuilds arithmetically from the element table.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    MB_IDLE,
    MB_FILL,
    MB_RD,
    MB_CW,
    MB_END
  } mb_state_t;

  localparam int unsigned MB_NUM_BG  = 6;
  localparam int unsigned MB_LAST_EL = 5;

  // Bit 'pos' of background 'bg': 0 -> all zero, k -> runs of 2**(5-k), low run set.
  function automatic logic bg_bit(input int unsigned bg, input int unsigned pos);
    if (bg == 0 || bg > 5) return 1'b0;
    return ((pos >> (5 - bg)) & 1) == 0;
  endfunction

  function automatic logic el_desc(input logic [2:0] el);
    return (el == 3'd3) || (el == 3'd4);
  endfunction

  function automatic logic el_exp_inv(input logic [2:0] el);
    return (el == 3'd2) || (el == 3'd4);
  endfunction

  function automatic logic el_wr_inv(input logic [2:0] el);
    return (el == 3'd1) || (el == 3'd3);
  endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int AW    = 10,
  parameter int WORDS = 256,
  parameter int BASE  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output mb_state_t     state_o,
  output logic [2:0]    el_o,
  output logic [2:0]    bg_o,
  output logic [AW-1:0] addr_o,
  output logic          start_acc_o,
  output logic          step_o
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WORDS - 1);
  localparam logic [AW-1:0]    A_LO   = AW'(BASE);
  localparam logic [AW-1:0]    A_HI   = AW'(BASE + WORDS - 1);

  mb_state_t        state;
  logic [2:0]       el, bg;
  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MB_IDLE;
      el    <= '0;
      bg    <= '0;
      addr  <= '0;
      wcnt  <= '0;
    end else begin
      case (state)
        MB_IDLE: if (start) begin
          state <= MB_FILL;
          el    <= '0;
          bg    <= '0;
          addr  <= A_LO;
          wcnt  <= '0;
        end
        MB_FILL: begin
          if (wcnt == W_LAST) begin
            wcnt  <= '0;
            el    <= 3'd1;
            addr  <= A_LO;
            state <= MB_RD;
          end else begin
            wcnt <= wcnt + 1'b1;
            addr <= addr + 1'b1;
          end
        end
        MB_RD: state <= MB_CW;
        MB_CW: begin
          state <= MB_RD;
          if (wcnt == W_LAST) begin
            wcnt <= '0;
            if (el == 3'(MB_LAST_EL)) begin
              if (bg == 3'(MB_NUM_BG - 1)) begin
                state <= MB_END;
              end else begin
                bg    <= bg + 1'b1;
                el    <= '0;
                addr  <= A_LO;
                state <= MB_FILL;
              end
            end else begin
              el   <= el + 1'b1;
              addr <= el_desc(el + 3'd1) ? A_HI : A_LO;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
            addr <= el_desc(el) ? addr - 1'b1 : addr + 1'b1;
          end
        end
        MB_END:  state <= MB_IDLE;
        default: state <= MB_IDLE;
      endcase
    end
  end

  assign state_o     = state;
  assign el_o        = el;
  assign bg_o        = bg;
  assign addr_o      = addr;
  assign start_acc_o = start && (state == MB_IDLE);
  assign step_o      = (state == MB_FILL) || (state == MB_CW);
endmodule

// File: rtl/mbist_pat.sv
module mbist_pat
  import mbist_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    bg,
  input  logic [2:0]    el,
  output logic [DW-1:0] exp_o,
  output logic [DW-1:0] wr_o
);
  logic [DW-1:0] pat_tbl [8];

  for (genvar g = 0; g < 8; g++) begin : g_bg
    for (genvar b = 0; b < DW; b++) begin : g_bit
      assign pat_tbl[g][b] = bg_bit(g, b);
    end
  end

  logic [DW-1:0] base;
  assign base  = pat_tbl[bg];
  assign exp_o = el_exp_inv(el) ? ~base : base;
  assign wr_o  = el_wr_inv(el)  ? ~base : base;
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          chk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] exp,
  output logic          err_o,
  output logic [AW-1:0] f_addr_o,
  output logic [DW-1:0] f_rdata_o,
  output logic [DW-1:0] f_exp_o
);
  logic miss;
  assign miss = chk && (rdata != exp);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_o     <= 1'b0;
      f_addr_o  <= '0;
      f_rdata_o <= '0;
      f_exp_o   <= '0;
    end else if (miss) begin
      err_o <= 1'b1;
      if (!err_o) begin
        f_addr_o  <= addr;
        f_rdata_o <= rdata;
        f_exp_o   <= exp;
      end
    end
  end
endmodule

// File: rtl/mbist_tick.sv
module mbist_tick #(
  parameter int STEP = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic tick_o
);
  localparam int TW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(STEP - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (step) begin
      if (cnt == T_LAST) begin
        cnt    <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mbist_march.sv
module mbist_march
  import mbist_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int WORDS     = 256,
  parameter int BASE      = 0,
  parameter int PROG_STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          err_flag,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_rdata,
  output logic [DW-1:0] fail_exp,
  output logic          prog_tick
);
  mb_state_t     state;
  logic [2:0]    el, bg;
  logic          start_acc, step;
  logic [DW-1:0] exp_d, wr_d;
  logic          fin_q;

  mbist_seq #(.AW(AW), .WORDS(WORDS), .BASE(BASE)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .state_o(state), .el_o(el), .bg_o(bg), .addr_o(ram_addr),
    .start_acc_o(start_acc), .step_o(step)
  );

  mbist_pat #(.DW(DW)) pat_i (
    .bg(bg), .el(el), .exp_o(exp_d), .wr_o(wr_d)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) cmp_i (
    .clk(clk), .rst(rst), .clr(start_acc), .chk(state == MB_CW),
    .addr(ram_addr), .rdata(ram_rdata), .exp(exp_d),
    .err_o(err_flag), .f_addr_o(fail_addr), .f_rdata_o(fail_rdata), .f_exp_o(fail_exp)
  );

  mbist_tick #(.STEP(PROG_STEP)) tick_i (
    .clk(clk), .rst(rst), .clr(start_acc), .step(step), .tick_o(prog_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || start_acc) fin_q <= 1'b0;
    else if (state == MB_END) fin_q <= 1'b1;
  end

  assign ram_we    = (state == MB_FILL) || ((state == MB_CW) && (el != 3'(MB_LAST_EL)));
  assign ram_wdata = wr_d;
  assign busy      = (state != MB_IDLE);
  assign done      = (state == MB_END);
  assign pass      = (fin_q || done) && !err_flag;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int WORDS = 256,
  parameter int BASE  = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] ram_addr,
  input logic          ram_we,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          err_flag,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_rdata,
  input logic [DW-1:0] fail_exp,
  input logic          prog_tick
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + WORDS - 1);

  a_r2_we_in_run: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (busy && !done));

  a_r3_addr_range: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ((ram_addr >= LO) && (ram_addr <= HI)));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(start && !busy)) |=> err_flag);

  a_r7_fail_hold: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(start && !busy)) |=>
      ($stable(fail_addr) && $stable(fail_rdata) && $stable(fail_exp)));

  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done) |=> busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  a_r9_pass_clean: assert property (@(posedge clk) disable iff (rst)
    pass |-> !err_flag);

  a_r10_tick_in_run: assert property (@(posedge clk) disable iff (rst)
    prog_tick |-> busy);
endmodule

bind mbist_march mbist_march_chk #(.AW(AW), .DW(DW), .WORDS(WORDS), .BASE(BASE)) chk_i (
  .clk(clk), .rst(rst), .start(start), .ram_addr(ram_addr), .ram_we(ram_we),
  .busy(busy), .done(done), .pass(pass), .err_flag(err_flag),
  .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_exp(fail_exp),
  .prog_tick(prog_tick)
);

// File: tb/mbist_march_tb_top.sv
`timescale 1ns/1ps
module mbist_march_tb_top;
  localparam int AW = 6, DW = 32, W = 16, BASE = 4, STEP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] ram_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [DW-1:0] ram_wdata;
  logic          busy, done, pass, err_flag, prog_tick;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_rdata, fail_exp;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbist_march #(.AW(AW), .DW(DW), .WORDS(W), .BASE(BASE), .PROG_STEP(STEP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .busy(busy), .done(done), .pass(pass), .err_flag(err_flag),
    .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_exp(fail_exp),
    .prog_tick(prog_tick)
  );

  // RAM model with per-address stuck-at masks and a one-shot read flip
  logic [DW-1:0] mem   [64];
  logic [DW-1:0] f_or  [64];
  logic [DW-1:0] f_and [64];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] rd_a;
  bit            flip_arm = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = '0; f_or[i] = '0; f_and[i] = '1;
    end
  end

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    rd_q <= mem[ram_addr];
    rd_a <= ram_addr;
  end

  assign ram_rdata = ((rd_q | f_or[rd_a]) & f_and[rd_a]) ^
                     ((flip_arm && rd_a == AW'(BASE + W - 1)) ? 32'h1 : 32'h0);

  function automatic logic [31:0] bgpat(input int k);
    case (k)
      0: return 32'h00000000;
      1: return 32'h0000FFFF;
      2: return 32'h00FF00FF;
      3: return 32'h0F0F0F0F;
      4: return 32'h33333333;
      default: return 32'h55555555;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < 64; i++) begin f_or[i] = '0; f_and[i] = '1; end
    flip_arm = 0;
  endtask

  // Runs one test; returns cycles to done, tick count and trace mismatches
  task automatic do_run(input bit mid_start, input bit flip_mode,
                        output int cyc, output int tk, output int terr, output bit tick_at_done);
    int c, bgk, r, q, e, w, ph;
    logic [AW-1:0] ea; logic ewe; logic [31:0] ed;
    tk = 0; terr = 0; tick_at_done = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    cyc = 1;
    forever begin
      if (prog_tick) tk++;
      if (done) begin tick_at_done = prog_tick; break; end
      c = cyc - 1;
      bgk = c / (11 * W); r = c % (11 * W);
      if (r < W) begin
        ea = AW'(BASE + r); ewe = 1; ed = bgpat(bgk);
      end else begin
        q = r - W; e = 1 + q / (2 * W); w = (q % (2 * W)) / 2; ph = q % 2;
        ea  = (e == 3 || e == 4) ? AW'(BASE + W - 1 - w) : AW'(BASE + w);
        ewe = (ph == 1) && (e != 5);
        ed  = (e == 1 || e == 3) ? ~bgpat(bgk) : bgpat(bgk);
      end
      if (ram_addr !== ea || ram_we !== ewe || (ewe && ram_wdata !== ed)) begin
        if (terr < 4)
          $display("trace mismatch c=%0d addr=%0d/%0d we=%0b/%0b", c, ram_addr, ea, ram_we, ewe);
        terr++;
      end
      if (cyc > 5000) break;
      if (flip_mode && cyc == 64 * W + 1) flip_arm = 1;
      start = mid_start && (cyc == 100 || cyc == 500);
      @(negedge clk);
      cyc++;
    end
    start = 0;
  endtask

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int cyc, tk, terr; bit tad;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);  check("R1 done", done, 0);
    check("R1 pass", pass, 0);  check("R1 err", err_flag, 0);
    check("R1 we", ram_we, 0);  check("R1 addr", ram_addr, 0);
    check("R1 tick", prog_tick, 0); check("R1 fail_addr", fail_addr, 0);

    // Run A: stuck-at-1 bit0 at addresses 12 and 9 -> first capture at 9 (R6, R7)
    f_or[12] = 32'h1; f_or[9] = 32'h1;
    do_run(0, 0, cyc, tk, terr, tad);
    check("R2 R6 run length with faults", cyc, 66 * W + 1);
    check("R2 R3 R4 R5 R6 trace with faults", terr, 0);
    check("R6 err", err_flag, 1);
    check("R6 pass", pass, 0);
    check("R7 fail_addr", fail_addr, 9);
    check("R7 fail_rdata", fail_rdata, 32'h1);
    check("R7 fail_exp", fail_exp, 32'h0);
    clear_faults();
    repeat (3) @(negedge clk);
    check("R7 hold after run", fail_addr, 9);

    // Run C: clean, with start pulses while busy (R8), clears capture (R7)
    do_run(1, 0, cyc, tk, terr, tad);
    check("R8 R2 run length", cyc, 66 * W + 1);
    check("R2 R3 R4 R5 clean trace", terr, 0);
    check("R9 pass at done", pass, 1);
    check("R9 busy at done", busy, 1);
    check("R10 tick count", tk, 36 * W / STEP);
    check("R7 cleared fail_addr", fail_addr, 0);
    check("R7 cleared fail_rdata", fail_rdata, 0);
    check("R6 err clear", err_flag, 0);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R9 idle after done", busy, 0);
    repeat (3) @(negedge clk);
    check("R9 pass held", pass, 1);

    // Run B: stuck-at-0 bit31 at address 7 -> first seen in element 2 (R5)
    f_and[7] = 32'h7FFFFFFF;
    do_run(0, 0, cyc, tk, terr, tad);
    check("R5 fail_addr", fail_addr, 7);
    check("R5 fail_rdata", fail_rdata, 32'h7FFFFFFF);
    check("R5 fail_exp", fail_exp, 32'hFFFFFFFF);
    check("R6 pass low", pass, 0);
    clear_faults();

    // Run D: flip only on the last compare (R12)
    do_run(0, 1, cyc, tk, terr, tad);
    check("R12 pass low at done", pass, 0);
    check("R12 fail_addr", fail_addr, BASE + W - 1);
    check("R12 fail_rdata", fail_rdata, 32'h55555554);
    check("R12 fail_exp", fail_exp, 32'h55555555);
    check("R12 tick with done", tad, 1);
    check("R12 R10 tick count", tk, 36 * W / STEP);
    clear_faults();

    // Run E: reset during a run (R11)
    f_or[BASE] = 32'h1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (50) @(negedge clk);
    check("R11 err before reset", err_flag, 1);
    rst = 1;
    @(negedge clk);
    check("R11 busy", busy, 0);
    check("R11 err", err_flag, 0);
    check("R11 addr", ram_addr, 0);
    check("R11 fail_addr", fail_addr, 0);
    check("R11 pass", pass, 0);
    rst = 0;
    clear_faults();
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule